// File: doc/BRIEF.md
# PCI-to-ISA Interrupt Router

This block steers level-sensitive interrupt requests onto sixteen ISA IRQ lines. Eight internal PCI functions and four external PCI interrupt pins are the sources. Each function picks its target IRQ from its own 8-bit interrupt-line byte. Each external pin picks its target from a 4-bit field in one of three steering bytes. The interrupt controller that receives the lines is outside the block.

The router does not decode the routing bytes continuously. It keeps one source bitmask per ISA line, plus a global mask of the last processed level of every source. A level change on a source is an event. The event first updates the global mask. It then sets or clears the source's bit in the mask of the line the source is routed to at that moment. That one mask is then ANDed with the global mask. Each output line is high while any bit of its mask is set. A line that is disabled or illegal only updates the global mask. An illegal target also raises an error pulse for one clock.

Top module: `irq_router`

## Requirements
- R1: While rst_n is low at a clock edge, every irq_out bit and route_err are cleared, and every source is taken as inactive.
- R2: Function n (0 to 7) is source n. Its target IRQ is the byte fn_line[8n+7:8n], and an asserted fn_req[n] on a legal target drives irq_out at that index high.
- R3: External pins A, B, C and D are sources 8, 9, 10 and 11, driven by pin_req[0] to pin_req[3]. Their target nibbles are steer_lo[7:4] for A, steer_mid[3:0] for B, steer_mid[7:4] for C and steer_hi[7:4] for D. steer_lo[3:0] and steer_hi[3:0] are not used.
- R4: A target value of 0 or 0xFF disables the source. Its events change no irq_out bit and raise no error.
- R5: Target 2 is illegal for every source. An event on an illegal target changes no irq_out bit and sets route_err high for exactly one clock.
- R6: The highest legal target is 14 for functions 2, 3 and 5, and 15 for every other source. Any target above the source's limit is illegal, as in R5.
- R7: Each irq_out bit is high while at least one source is recorded in that line's mask. Several sources can share a line, and the line falls only when the last of them deasserts.
- R8: An event sets or clears its bit in the current target's mask and then ANDs that mask with the global level mask. The masks of other lines are not touched. A bit left on a former target therefore holds its line high until an event on that line prunes it.
- R9: At most one event is processed per clock, with the lowest-numbered pending source first. A processed event shows on irq_out in the cycle after the clock edge that takes it.
- R10: A change of a routing byte or nibble on its own changes no irq_out bit. Only level events are acted on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fn_req | input | 8 | Interrupt level of internal functions 0..7 |
| fn_line | input | 64 | Interrupt-line byte per function, function n in bits 8n+7:8n |
| pin_req | input | 4 | Levels of external pins A..D (bit 0 = A) |
| steer_lo | input | 8 | Steering byte, pin A target in bits 7:4 |
| steer_mid | input | 8 | Steering byte, pin B in bits 3:0, pin C in bits 7:4 |
| steer_hi | input | 8 | Steering byte, pin D target in bits 7:4 |
| irq_out | output | 16 | ISA IRQ levels, bit k = IRQ k |
| route_err | output | 1 | One-clock pulse per event on an illegal target |

## Verification
Single sources are raised on distinct targets, and each pin is raised alone with a different nibble value. These tests catch a function indexed with the wrong byte, or a pin read from the wrong nibble. The disabled codes, target 2, and the per-source upper limits are tried on sources on both sides of each limit. This tells the disabled path, which is silent, apart from the illegal path, which pulses route_err, and the 14-limit functions apart from the 15-limit ones. Two functions share one line and deassert one at a time to show the OR. Two simultaneous changes on different lines are sampled cycle by cycle to show the ascending one-per-clock order. A source is rerouted while asserted and then deasserted. This shows that the old line stays stuck until a second source's event on that line prunes the stale bit.

// File: rtl/irq_route_pkg.sv
// Shared types for the interrupt router.
package irq_route_pkg;

    // Outcome of decoding one source's routing value.
    typedef enum logic [1:0] {
        RT_OFF = 2'd0,   // target 0 or 0xFF: source disabled
        RT_BAD = 2'd1,   // illegal target: error pulse, no line update
        RT_OK  = 2'd2    // legal target: update that line's mask
    } route_kind_e;

endpackage

// File: rtl/irq_src_pick.sv
// Picks the lowest-numbered pending source.
// Assumes: pend is a plain bit vector; any = 0 means idx is don't-care (0).
module irq_src_pick #(
    parameter int NUM_SRC = 16,
    localparam int IW = $clog2(NUM_SRC)
) (
    input  logic [NUM_SRC-1:0] pend,
    output logic               any,
    output logic [IW-1:0]      idx
);

    // Scan downward so the lowest pending index is the last one assigned.
    always_comb begin
        any = 1'b0;
        idx = '0;
        for (int i = NUM_SRC - 1; i >= 0; i--) begin
            if (pend[i]) begin
                any = 1'b1;
                idx = IW'(i);
            end
        end
    end

endmodule

// File: rtl/irq_tgt_decode.sv
// Maps a source number to its raw routing value and classifies that value.
// Assumes: pins occupy source numbers PIN_BASE..PIN_BASE+NUM_PIN-1 and do not
// overlap the function numbers; other source numbers read as disabled.
module irq_tgt_decode
    import irq_route_pkg::*;
#(
    parameter int NUM_SRC  = 16,
    parameter int NUM_FN   = 8,
    parameter int NUM_PIN  = 4,
    parameter int PIN_BASE = 8,
    parameter int NUM_IRQ  = 16,
    parameter logic [NUM_SRC-1:0] LOW_LIMIT = 16'h002C,
    localparam int IW   = $clog2(NUM_SRC),
    localparam int IRQW = $clog2(NUM_IRQ)
) (
    input  logic [IW-1:0]         src,
    input  logic [NUM_FN*8-1:0]   fn_line,
    input  logic [NUM_PIN*4-1:0]  pin_nib,
    output route_kind_e           kind,
    output logic [IRQW-1:0]       tgt
);

    localparam int MAX_FULL = NUM_IRQ - 1;
    localparam int MAX_LOW  = NUM_IRQ - 2;

    logic [7:0] raw;
    int         limit;

    // Fetch the routing value belonging to the selected source.
    always_comb begin
        raw = 8'h00;
        for (int f = 0; f < NUM_FN; f++) begin
            if (int'(src) == f) raw = fn_line[f*8 +: 8];
        end
        for (int p = 0; p < NUM_PIN; p++) begin
            if (int'(src) == PIN_BASE + p) raw = {4'h0, pin_nib[p*4 +: 4]};
        end
    end

    // Classify the value against the disabled codes and the per-source limit.
    always_comb begin
        limit = LOW_LIMIT[src] ? MAX_LOW : MAX_FULL;
        if (raw == 8'h00 || raw == 8'hFF) begin
            kind = RT_OFF;
        end else if (raw == 8'h02 || int'(raw) > limit) begin
            kind = RT_BAD;
        end else begin
            kind = RT_OK;
        end
    end

    assign tgt = raw[IRQW-1:0];

endmodule

// File: rtl/irq_mask_bank.sv
// Holds the global source-level mask and one source mask per IRQ line.
// Assumes: at most one event per clock; ev_ok is meaningful only with ev.
module irq_mask_bank #(
    parameter int NUM_SRC = 16,
    parameter int NUM_IRQ = 16,
    localparam int IW   = $clog2(NUM_SRC),
    localparam int IRQW = $clog2(NUM_IRQ)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ev,
    input  logic [IW-1:0]      ev_src,
    input  logic               ev_lvl,
    input  logic               ev_ok,
    input  logic [IRQW-1:0]    ev_tgt,
    output logic [NUM_SRC-1:0] act,
    output logic [NUM_IRQ-1:0] irq_lvl
);

    logic [NUM_SRC-1:0] act_nx;

    // Next global mask: the event's source takes its new level.
    always_comb begin
        act_nx = act;
        if (ev) act_nx[ev_src] = ev_lvl;
    end

    // Global mask register, updated on every event regardless of routing.
    always_ff @(posedge clk) begin
        if (!rst_n) act <= '0;
        else        act <= act_nx;
    end

    for (genvar g = 0; g < NUM_IRQ; g++) begin : g_line
        logic [NUM_SRC-1:0] mask_q;
        logic [NUM_SRC-1:0] mask_upd;

        // Candidate mask: event bit written into this line's mask.
        always_comb begin
            mask_upd = mask_q;
            mask_upd[ev_src] = ev_lvl;
        end

        // Update only the addressed line, pruned against the global mask.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                mask_q <= '0;
            end else if (ev && ev_ok && ev_tgt == IRQW'(g)) begin
                mask_q <= mask_upd & act_nx;
            end
        end

        assign irq_lvl[g] = |mask_q;
    end

endmodule

// File: rtl/irq_router.sv
// Routes function and pin interrupt levels onto ISA IRQ lines.
// Assumes: source levels are synchronous to clk; routing inputs are static
// around events (they are sampled only in the cycle an event is taken).
module irq_router
    import irq_route_pkg::*;
#(
    parameter int NUM_FN   = 8,
    parameter int NUM_PIN  = 4,
    parameter int PIN_BASE = 8,
    parameter int NUM_SRC  = 16,
    parameter int NUM_IRQ  = 16,
    parameter logic [NUM_SRC-1:0] LOW_LIMIT = 16'h002C
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_FN-1:0]    fn_req,
    input  logic [NUM_FN*8-1:0]  fn_line,
    input  logic [NUM_PIN-1:0]   pin_req,
    input  logic [7:0]           steer_lo,
    input  logic [7:0]           steer_mid,
    input  logic [7:0]           steer_hi,
    output logic [NUM_IRQ-1:0]   irq_out,
    output logic                 route_err
);

    localparam int IW   = $clog2(NUM_SRC);
    localparam int IRQW = $clog2(NUM_IRQ);

    logic [NUM_SRC-1:0]  cur_lvl;
    logic [NUM_SRC-1:0]  act_q;
    logic [NUM_SRC-1:0]  pending;
    logic                ev_any;
    logic [IW-1:0]       ev_src;
    logic                ev_ok;
    route_kind_e         ev_kind;
    logic [IRQW-1:0]     ev_tgt;
    logic [NUM_PIN*4-1:0] pin_nib;
    logic                unused_steer;

    // Pin nibbles packed with pin A in the lowest field.
    assign pin_nib      = {steer_hi[7:4], steer_mid[7:4], steer_mid[3:0], steer_lo[7:4]};
    assign unused_steer = ^{steer_lo[3:0], steer_hi[3:0]};

    // Gather all source levels at their source numbers.
    always_comb begin
        cur_lvl = '0;
        cur_lvl[NUM_FN-1:0]          = fn_req;
        cur_lvl[PIN_BASE +: NUM_PIN] = pin_req;
    end

    assign pending = cur_lvl ^ act_q;

    irq_src_pick #(.NUM_SRC(NUM_SRC)) u_pick (
        .pend (pending),
        .any  (ev_any),
        .idx  (ev_src)
    );

    irq_tgt_decode #(
        .NUM_SRC   (NUM_SRC),
        .NUM_FN    (NUM_FN),
        .NUM_PIN   (NUM_PIN),
        .PIN_BASE  (PIN_BASE),
        .NUM_IRQ   (NUM_IRQ),
        .LOW_LIMIT (LOW_LIMIT)
    ) u_dec (
        .src     (ev_src),
        .fn_line (fn_line),
        .pin_nib (pin_nib),
        .kind    (ev_kind),
        .tgt     (ev_tgt)
    );

    assign ev_ok = (ev_kind == RT_OK);

    irq_mask_bank #(.NUM_SRC(NUM_SRC), .NUM_IRQ(NUM_IRQ)) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .ev      (ev_any),
        .ev_src  (ev_src),
        .ev_lvl  (cur_lvl[ev_src]),
        .ev_ok   (ev_ok),
        .ev_tgt  (ev_tgt),
        .act     (act_q),
        .irq_lvl (irq_out)
    );

    // One-clock error pulse for an event on an illegal target.
    always_ff @(posedge clk) begin
        if (!rst_n) route_err <= 1'b0;
        else        route_err <= ev_any && (ev_kind == RT_BAD);
    end

endmodule

// File: rtl/irq_router_chk.sv
// Property checker for irq_router, attached by bind below.
// Assumes: rst_n is held low from time zero through the first clock edge.
module irq_router_chk #(
    parameter int NUM_SRC = 16,
    parameter int NUM_IRQ = 16
) (
    input logic               clk,
    input logic               rst_n,
    input logic [NUM_IRQ-1:0] irq_out,
    input logic               route_err,
    input logic               ev,
    input logic               ev_ok,
    input logic [NUM_SRC-1:0] act
);

    // R9: no event this cycle means the lines hold next cycle.
    a_r9_hold_without_event: assert property (@(posedge clk) disable iff (!rst_n)
        !ev |=> $stable(irq_out));

    // R9: the global mask changes by at most one source per clock.
    a_r9_one_source_per_clock: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(act ^ $past(act)) <= 1);

    // R5: an error pulse follows a taken event and leaves the lines alone.
    a_r5_err_after_event: assert property (@(posedge clk) disable iff (!rst_n)
        route_err |-> $past(ev) && $stable(irq_out));

    // R5: IRQ 2 and IRQ 0 are never driven.
    a_r5_irq2_never: assert property (@(posedge clk) disable iff (!rst_n)
        irq_out[2] == 1'b0 && irq_out[0] == 1'b0);

    // R7: a line can rise only after a legal routed event.
    a_r7_rise_needs_legal: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_out & ~$past(irq_out)) != '0 |-> $past(ev && ev_ok));

endmodule

bind irq_router irq_router_chk #(.NUM_SRC(NUM_SRC), .NUM_IRQ(NUM_IRQ)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .irq_out   (irq_out),
    .route_err (route_err),
    .ev        (ev_any),
    .ev_ok     (ev_ok),
    .act       (act_q)
);

// File: tb/sim_irq_router.sv
// Directed bench for irq_router: one task per scenario.
module sim_irq_router;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  fn_req = '0;
    logic [63:0] fn_line = '0;
    logic [3:0]  pin_req = '0;
    logic [7:0]  steer_lo = '0;
    logic [7:0]  steer_mid = '0;
    logic [7:0]  steer_hi = '0;
    logic [15:0] irq_out;
    logic        route_err;

    int n_chk = 0;
    int n_bad = 0;
    int err_seen = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    irq_router u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .fn_req    (fn_req),
        .fn_line   (fn_line),
        .pin_req   (pin_req),
        .steer_lo  (steer_lo),
        .steer_mid (steer_mid),
        .steer_hi  (steer_hi),
        .irq_out   (irq_out),
        .route_err (route_err)
    );

    // Counts error-pulse cycles, sampled between edges.
    always @(negedge clk) if (rst_n && route_err) err_seen++;

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input logic [15:0] got, input logic [15:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic set_line(input int f, input logic [7:0] v);
        fn_line[f*8 +: 8] = v;
    endtask

    task automatic t_reset();
        check("R1 irq after reset", irq_out, 16'h0000);
        check("R1 err after reset", {15'h0, route_err}, 16'h0000);
    endtask

    task automatic t_func();
        set_line(3, 8'd7); fn_req[3] = 1'b1; step(2);
        check("R2 fn3 to IRQ7", irq_out, 16'h0080);
        fn_req[3] = 1'b0; step(2);
        check("R2 fn3 released", irq_out, 16'h0000);
        set_line(0, 8'd4); fn_req[0] = 1'b1; step(2);
        check("R2 fn0 to IRQ4", irq_out, 16'h0010);
        fn_req[0] = 1'b0; step(2);
        check("R2 fn0 released", irq_out, 16'h0000);
    endtask

    task automatic t_pins();
        steer_lo = 8'h90; steer_mid = 8'hBA; steer_hi = 8'hC3;
        pin_req = 4'b0001; step(3);
        check("R3 pin A to IRQ9", irq_out, 16'h0200);
        pin_req = 4'b0011; step(3);
        check("R3 pin B to IRQ10", irq_out, 16'h0600);
        pin_req = 4'b0111; step(3);
        check("R3 pin C to IRQ11", irq_out, 16'h0E00);
        pin_req = 4'b1111; step(3);
        check("R3 pin D to IRQ12", irq_out, 16'h1E00);
        pin_req = 4'b0000; step(6);
        check("R3 pins released", irq_out, 16'h0000);
    endtask

    task automatic t_disabled();
        int e0 = err_seen;
        set_line(1, 8'h00); set_line(4, 8'hFF);
        fn_req[1] = 1'b1; fn_req[4] = 1'b1; step(3);
        check("R4 disabled targets", irq_out, 16'h0000);
        fn_req[1] = 1'b0; fn_req[4] = 1'b0; step(3);
        check("R4 no error on disabled", 16'(err_seen - e0), 16'd0);
    endtask

    task automatic t_illegal();
        int e0 = err_seen;
        set_line(6, 8'd2); fn_req[6] = 1'b1; step(3);
        check("R5 IRQ2 lines", irq_out, 16'h0000);
        check("R5 one pulse on assert", 16'(err_seen - e0), 16'd1);
        fn_req[6] = 1'b0; step(3);
        check("R5 one pulse on release", 16'(err_seen - e0), 16'd2);
        steer_hi = 8'h20; pin_req[3] = 1'b1; step(3);
        check("R5 pin D to IRQ2 lines", irq_out, 16'h0000);
        check("R5 pin D pulse", 16'(err_seen - e0), 16'd3);
        pin_req[3] = 1'b0; step(3);
    endtask

    task automatic t_limits();
        int e0 = err_seen;
        set_line(2, 8'd15); fn_req[2] = 1'b1; step(3);
        check("R6 fn2 IRQ15 illegal lines", irq_out, 16'h0000);
        check("R6 fn2 IRQ15 error", 16'(err_seen - e0), 16'd1);
        fn_req[2] = 1'b0; step(3);
        e0 = err_seen;
        set_line(5, 8'd14); fn_req[5] = 1'b1; step(3);
        check("R6 fn5 IRQ14 legal", irq_out, 16'h4000);
        fn_req[5] = 1'b0;
        set_line(7, 8'd15); fn_req[7] = 1'b1; step(4);
        check("R6 fn7 IRQ15 legal", irq_out, 16'h8000);
        check("R6 no error on legal", 16'(err_seen - e0), 16'd0);
        fn_req[7] = 1'b0;
        set_line(1, 8'd16); fn_req[1] = 1'b1; step(4);
        check("R6 fn1 IRQ16 illegal", irq_out, 16'h0000);
        check("R6 fn1 IRQ16 error", 16'(err_seen - e0), 16'd1);
        fn_req[1] = 1'b0; step(3);
        steer_lo = 8'hF0; pin_req[0] = 1'b1; step(3);
        check("R6 pin A IRQ15 legal", irq_out, 16'h8000);
        pin_req[0] = 1'b0; step(3);
    endtask

    task automatic t_share();
        set_line(1, 8'd10); set_line(4, 8'd10);
        fn_req[1] = 1'b1; fn_req[4] = 1'b1; step(3);
        check("R7 shared line high", irq_out, 16'h0400);
        fn_req[1] = 1'b0; step(3);
        check("R7 one sharer left", irq_out, 16'h0400);
        fn_req[4] = 1'b0; step(3);
        check("R7 last sharer gone", irq_out, 16'h0000);
    endtask

    task automatic t_order();
        set_line(1, 8'd3); set_line(4, 8'd4);
        fn_req[1] = 1'b1; fn_req[4] = 1'b1; step(1);
        check("R9 lower source first", irq_out, 16'h0008);
        step(1);
        check("R9 second source next clock", irq_out, 16'h0018);
        fn_req[1] = 1'b0; fn_req[4] = 1'b0; step(1);
        check("R9 lower release first", irq_out, 16'h0010);
        step(1);
        check("R9 second release", irq_out, 16'h0000);
    endtask

    task automatic t_prune();
        set_line(6, 8'd5); fn_req[6] = 1'b1; step(3);
        check("R8 fn6 on IRQ5", irq_out, 16'h0020);
        set_line(6, 8'd9); step(3);
        check("R10 reroute alone no change", irq_out, 16'h0020);
        fn_req[6] = 1'b0; step(3);
        check("R8 stale bit holds IRQ5", irq_out, 16'h0020);
        set_line(7, 8'd5); fn_req[7] = 1'b1; step(3);
        check("R8 fn7 on IRQ5", irq_out, 16'h0020);
        fn_req[7] = 1'b0; step(3);
        check("R8 stale bit pruned", irq_out, 16'h0000);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        step(3);
        t_reset();
        rst_n = 1'b1;
        step(2);
        t_func();
        t_pins();
        t_disabled();
        t_illegal();
        t_limits();
        t_share();
        t_order();
        t_prune();
        finish_run();
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #800000;
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

endmodule